// File: doc/BRIEF.md
# System Clock Source Switcher

This block decides which of up to eight oscillator sources drives the system clock. It also derives a divided system tick from that choice through a post-divider that can change its ratio gradually. The oscillators are not part of the block. Each one is represented by two inputs, sampled in the block's reference clock domain: a ready flag that says the source is present and stable, and a phase level that reflects its present output level.

Software drives a switch through a control register. It writes the wanted source code and sets a go bit. The block then treats the switch as a request, not a command:

- If the wanted source is not ready when the request is evaluated, the request is refused. The go bit drops and the active-source field keeps its old value.
- Otherwise the block waits for a cycle in which both the old and the new source sit low, and changes the selection there.

A second register holds the post-divider ratio. It also holds two slewing enables, one per direction of frequency change, and a step-dwell field. When slewing is enabled for the direction of a change, the effective ratio walks toward the new ratio one unit at a time. A busy bit stays set until the new ratio is in effect. Both registers are guarded by a two-word key sequence, so a stray write cannot change the clock.

Top module: `sysclk_switch`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - the active source is RESET_SRC (0 by default) and the source gate is one-hot for it;
  - `ctrl_q` reads the active source only, with every other field zero;
  - `slew_q` reads 0;
  - the effective post-divide field `post_div_now` is 0.
- R2: The register bus has three addresses: 0 is control, 1 is slew and 2 is key. A write to control or slew takes effect only if it directly follows a write of 32'h5A17C3E9 and then a write of 32'hA5E83C16, both to address 2. Any other intervening write cancels the sequence. Each unlock admits exactly one register write. A write made while locked changes nothing.
- R3: In the control register:
  - bits [14:12] hold the active source and are read-only;
  - bits [10:8] hold the requested source code;
  - bit 0 is the go bit, which software sets by writing 1;
  - all other bits read 0.
- R4: The decision is taken at each clock edge while go is set. If the requested source's ready input is low at that edge, the request is refused: go clears at that edge and the active source is unchanged. This also holds when ready falls while the request is waiting.
- R5: If the requested source is ready, the active source becomes the requested one at the first edge where the phase inputs of both the old and the new source are low. Go clears at that same edge.
- R6: While go is set, a write to the control register, even an unlocked one, is ignored.
- R7: The source gate output is one-hot and marks the active source at all times.
- R8: In the slew register:
  - bit 0 is busy (read-only);
  - bit 1 enables slewing when the ratio rises, which is a downward frequency change;
  - bit 2 enables slewing when the ratio falls;
  - bits [10:8] are the step dwell;
  - bits [23:20] are the post-divide field.
  
  With the effective field at p, `sys_tick` pulses once every p+1 clock cycles.
- R9: A post-divide write whose direction has slewing disabled moves the effective field to the new value one cycle after the write. Busy is set for exactly that one cycle. A write of the current value leaves busy clear.
- R10: A post-divide write whose direction has slewing enabled moves the effective field by exactly one step every s+1 cycles, where s is the step dwell. Busy stays set for |new−old|·(s+1) cycles.
- R11: The direction is chosen by comparing the new ratio with the current effective ratio. Bit 1 governs increases only and bit 2 governs decreases only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 slew, 2 key |
| wr_data | input | 32 | Write data |
| src_ready | input | N_SRC | Per-source present-and-stable flag |
| src_phase | input | N_SRC | Per-source sampled output level |
| ctrl_q | output | 32 | Control register readback |
| slew_q | output | 32 | Slew register readback, with busy |
| cur_src | output | 3 | Active source code |
| src_gate | output | N_SRC | One-hot enable of the active source |
| post_div_now | output | 4 | Effective post-divide field |
| sys_tick | output | 1 | Divided system tick, one pulse per ratio period |

## Verification
The bench builds the block with its defaults: N_SRC of 8, RESET_SRC of 0 and the stated key words. With these values every 3-bit source code is a real source, so random targets cover the whole select field. The full 4-bit post-divide range and the full 3-bit dwell range are also in reach, which lets the bench exercise the longest slews (fifteen steps at an eight-cycle dwell) as well as jumps. Random ready and phase patterns are applied per cycle against a bench model of the refuse-or-wait decision, alongside directed refusals, waits on a high phase and locked writes.

// File: rtl/sysclk_sw_pkg.sv
// Package: shared field positions, bus addresses, key words and types for
// the system clock source switcher. Assumes a 32-bit register bus.
package sysclk_sw_pkg;

    localparam int SEL_W    = 3;   // source code width (up to eight sources)
    localparam int STEP_W   = 3;   // slew dwell field width
    localparam int PDIV_W   = 4;   // post-divide field width

    // Control register field positions
    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_REQ_LSB = 8;
    localparam int CTRL_CUR_LSB = 12;

    // Slew register field positions
    localparam int SLEW_BUSY_BIT = 0;
    localparam int SLEW_DN_BIT   = 1;
    localparam int SLEW_UP_BIT   = 2;
    localparam int SLEW_STEP_LSB = 8;
    localparam int SLEW_PDIV_LSB = 20;

    // Bus addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SLEW = 2'd1;
    localparam logic [1:0] ADDR_KEY  = 2'd2;

    typedef enum logic [1:0] {
        KEY_SHUT = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    typedef struct packed {
        logic              dn_en;  // slew when the ratio rises
        logic              up_en;  // slew when the ratio falls
        logic [STEP_W-1:0] step;   // dwell per step, minus one
        logic [PDIV_W-1:0] pdiv;   // requested post-divide field
    } slew_cfg_t;

endpackage

// File: rtl/sysclk_sw_regs.sv
// Module: register file with key-guarded writes.
// Holds the requested source, the go bit and the slew configuration.
// Assumes: one write per cycle; the go bit is cleared only by sw_done.
module sysclk_sw_regs
    import sysclk_sw_pkg::*;
#(
    parameter logic [31:0] KEY_A = 32'h5A17C3E9,
    parameter logic [31:0] KEY_B = 32'hA5E83C16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             sw_done,
    input  logic [SEL_W-1:0] cur_sel,
    input  logic             busy,
    output logic [SEL_W-1:0] req_sel,
    output logic             sw_req,
    output slew_cfg_t        cfg,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      slew_q
);

    key_state_e key_q;
    logic       ctrl_wr_ok;
    logic       slew_wr_ok;

    assign ctrl_wr_ok = wr_en && (wr_addr == ADDR_CTRL) && (key_q == KEY_OPEN) && !sw_req;
    assign slew_wr_ok = wr_en && (wr_addr == ADDR_SLEW) && (key_q == KEY_OPEN);

    // Key sequencer: two ordered words open the gate for one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= KEY_SHUT;
        end else if (wr_en) begin
            if (wr_addr == ADDR_KEY && wr_data == KEY_A)
                key_q <= KEY_HALF;
            else if (wr_addr == ADDR_KEY && wr_data == KEY_B && key_q == KEY_HALF)
                key_q <= KEY_OPEN;
            else
                key_q <= KEY_SHUT;
        end
    end

    // Control fields: requested source and go bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sel <= '0;
            sw_req  <= 1'b0;
        end else if (sw_done) begin
            sw_req <= 1'b0;
        end else if (ctrl_wr_ok) begin
            req_sel <= wr_data[CTRL_REQ_LSB +: SEL_W];
            sw_req  <= wr_data[CTRL_GO_BIT];
        end
    end

    // Slew configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (slew_wr_ok) begin
            cfg.dn_en <= wr_data[SLEW_DN_BIT];
            cfg.up_en <= wr_data[SLEW_UP_BIT];
            cfg.step  <= wr_data[SLEW_STEP_LSB +: STEP_W];
            cfg.pdiv  <= wr_data[SLEW_PDIV_LSB +: PDIV_W];
        end
    end

    // Readback composition for the control register.
    always_comb begin
        ctrl_q = '0;
        ctrl_q[CTRL_CUR_LSB +: SEL_W] = cur_sel;
        ctrl_q[CTRL_REQ_LSB +: SEL_W] = req_sel;
        ctrl_q[CTRL_GO_BIT]           = sw_req;
    end

    // Readback composition for the slew register.
    always_comb begin
        slew_q = '0;
        slew_q[SLEW_BUSY_BIT]              = busy;
        slew_q[SLEW_DN_BIT]                = cfg.dn_en;
        slew_q[SLEW_UP_BIT]                = cfg.up_en;
        slew_q[SLEW_STEP_LSB +: STEP_W]    = cfg.step;
        slew_q[SLEW_PDIV_LSB +: PDIV_W]    = cfg.pdiv;
    end

    AST_LOCKED_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && key_q != KEY_OPEN) |=> $stable(req_sel)); // R2
    AST_GO_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_req) |-> $past(sw_done)); // R5
    AST_BUSY_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_done) |=> (sw_req && $stable(req_sel))); // R6

endmodule

// File: rtl/sysclk_sw_select.sv
// Module: source selection decision.
// While a request is pending, it refuses the request if the target is not
// ready, and otherwise commits on a cycle where the old and new phases are
// both low. Assumes the phase inputs are already in the clk domain.
// Source codes at or above N_SRC count as absent.
module sysclk_sw_select
    import sysclk_sw_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int RESET_SRC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [N_SRC-1:0] src_ready,
    input  logic [N_SRC-1:0] src_phase,
    output logic [SEL_W-1:0] cur_sel,
    output logic [N_SRC-1:0] src_gate,
    output logic             sw_done
);

    localparam int CODES = 1 << SEL_W;

    logic [CODES-1:0] ready_x;
    logic [CODES-1:0] phase_x;
    logic             tgt_ok;
    logic             both_low;
    logic             commit;

    // Widen the source vectors to the full code space; missing codes are absent.
    for (genvar g = 0; g < CODES; g++) begin : g_widen
        if (g < N_SRC) begin : g_real
            assign ready_x[g] = src_ready[g];
            assign phase_x[g] = src_phase[g];
        end else begin : g_none
            assign ready_x[g] = 1'b0;
            assign phase_x[g] = 1'b0;
        end
    end

    assign tgt_ok   = ready_x[req_sel];
    assign both_low = !phase_x[cur_sel] && !phase_x[req_sel];
    assign commit   = sw_req && tgt_ok && both_low;
    assign sw_done  = sw_req && (!tgt_ok || both_low);

    // Active source register: moves only on a clean commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_sel <= SEL_W'(RESET_SRC);
        else if (commit)
            cur_sel <= req_sel;
    end

    // One-hot gate decode for the active source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign src_gate[g] = (cur_sel == SEL_W'(g));
    end

    function automatic logic [CODES-1:0] code_oh(input logic [SEL_W-1:0] c);
        return CODES'(1) << c;
    endfunction

    AST_REFUSE_KEEPS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !tgt_ok) |=> $stable(cur_sel)); // R4
    AST_SWITCH_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sel != $past(cur_sel)) |->
        (($past(phase_x) & (code_oh(cur_sel) | code_oh($past(cur_sel)))) == '0)); // R5
    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_gate) == 1); // R7

endmodule

// File: rtl/sysclk_sw_postdiv.sv
// Module: post-divider with slew stepping and busy flag.
// The effective field walks toward the requested field one step per dwell
// when slewing is enabled for that direction; otherwise it jumps.
// The tick pulses once per (effective + 1) cycles.
module sysclk_sw_postdiv
    import sysclk_sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slew_cfg_t         cfg,
    output logic [PDIV_W-1:0] eff_div,
    output logic              busy,
    output logic              sys_tick
);

    logic [STEP_W-1:0] dwell;
    logic [PDIV_W-1:0] cnt;
    logic              rising;
    logic              slew_on;

    assign rising  = cfg.pdiv > eff_div;
    assign slew_on = rising ? cfg.dn_en : cfg.up_en;
    assign busy    = (eff_div != cfg.pdiv);

    // Effective ratio and dwell counter: step, jump or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_div <= '0;
            dwell   <= '0;
        end else if (!busy) begin
            dwell <= '0;
        end else if (!slew_on) begin
            eff_div <= cfg.pdiv;
            dwell   <= '0;
        end else if (dwell >= cfg.step) begin
            eff_div <= rising ? eff_div + PDIV_W'(1) : eff_div - PDIV_W'(1);
            dwell   <= '0;
        end else begin
            dwell <= dwell + STEP_W'(1);
        end
    end

    // Tick counter: wraps once it reaches the effective ratio.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt >= eff_div)
            cnt <= '0;
        else
            cnt <= cnt + PDIV_W'(1);
    end

    assign sys_tick = (cnt >= eff_div);

    AST_SLEW_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_div != $past(eff_div) && $past(slew_on)) |->
        (eff_div == $past(eff_div) + PDIV_W'(1) || eff_div == $past(eff_div) - PDIV_W'(1))); // R10
    AST_MOVE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_div != $past(eff_div)) |-> $past(busy)); // R9
    AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(slew_on) && $stable(cfg.pdiv)) |-> !busy); // R11

endmodule

// File: rtl/sysclk_switch.sv
// Module: top of the system clock source switcher.
// Ties the key-guarded registers, the source decision and the slewing
// post-divider together. Assumes all inputs are synchronous to clk.
module sysclk_switch
    import sysclk_sw_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter int          RESET_SRC = 0,
    parameter logic [31:0] KEY_A     = 32'h5A17C3E9,
    parameter logic [31:0] KEY_B     = 32'hA5E83C16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [N_SRC-1:0]  src_ready,
    input  logic [N_SRC-1:0]  src_phase,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       slew_q,
    output logic [SEL_W-1:0]  cur_src,
    output logic [N_SRC-1:0]  src_gate,
    output logic [PDIV_W-1:0] post_div_now,
    output logic              sys_tick
);

    logic [SEL_W-1:0] req_sel;
    logic             sw_req;
    logic             sw_done;
    logic             busy;
    slew_cfg_t        cfg;

    sysclk_sw_regs #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sw_done (sw_done),
        .cur_sel (cur_src),
        .busy    (busy),
        .req_sel (req_sel),
        .sw_req  (sw_req),
        .cfg     (cfg),
        .ctrl_q  (ctrl_q),
        .slew_q  (slew_q)
    );

    sysclk_sw_select #(
        .N_SRC     (N_SRC),
        .RESET_SRC (RESET_SRC)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .req_sel   (req_sel),
        .src_ready (src_ready),
        .src_phase (src_phase),
        .cur_sel   (cur_src),
        .src_gate  (src_gate),
        .sw_done   (sw_done)
    );

    sysclk_sw_postdiv u_postdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .eff_div  (post_div_now),
        .busy     (busy),
        .sys_tick (sys_tick)
    );

endmodule

// File: tb/sysclk_switch_bench.sv
module sysclk_switch_bench;

    localparam logic [31:0] KA = 32'h5A17C3E9;
    localparam logic [31:0] KB = 32'hA5E83C16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [7:0]  src_ready;
    logic [7:0]  src_phase;
    logic [31:0] ctrl_q;
    logic [31:0] slew_q;
    logic [2:0]  cur_src;
    logic [7:0]  src_gate;
    logic [3:0]  post_div_now;
    logic        sys_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sysclk_switch u_sysclk_switch (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .src_ready (src_ready), .src_phase (src_phase),
        .ctrl_q (ctrl_q), .slew_q (slew_q), .cur_src (cur_src),
        .src_gate (src_gate), .post_div_now (post_div_now), .sys_tick (sys_tick)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_clk();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step_clk();
        wr_en = 1'b0;
    endtask

    task automatic key_wr(input logic [1:0] a, input logic [31:0] d);
        wr(2'd2, KA);
        wr(2'd2, KB);
        wr(a, d);
    endtask

    function automatic logic [31:0] ctrl_word(input int src, input bit go);
        return (32'(src) << 8) | 32'(go);
    endfunction

    function automatic logic [31:0] slew_word(input int pd, input int st, input bit dn, input bit up);
        return (32'(pd) << 20) | (32'(st) << 8) | (32'(up) << 2) | (32'(dn) << 1);
    endfunction

    function automatic int exp_busy(input int a, input int b, input int s, input bit dn, input bit up);
        int d;
        bit sl;
        d  = (b > a) ? b - a : a - b;
        sl = (b > a) ? dn : up;
        if (d == 0) return 0;
        return sl ? d * (s + 1) : 1;
    endfunction

    task automatic pdiv_case(input string req, input int b, input int s, input bit dn, input bit up);
        int a, cnt, prev;
        bit jumpy;
        a = int'(post_div_now);
        key_wr(2'd1, slew_word(b, s, dn, up));
        check({req, " slew readback"}, slew_q & 32'hFFFF_FFFE, slew_word(b, s, dn, up));
        cnt = 0; jumpy = 0; prev = a;
        while (slew_q[0] && cnt < 400) begin
            cnt++;
            step_clk();
            if (post_div_now != 4'(prev)) begin
                if (!((int'(post_div_now) == prev + 1) || (int'(post_div_now) == prev - 1)))
                    jumpy = 1;
                prev = int'(post_div_now);
            end
        end
        check({req, " busy cycles"}, 32'(cnt), 32'(exp_busy(a, b, s, dn, up)));
        check({req, " final ratio"}, 32'(post_div_now), 32'(b));
        if (exp_busy(a, b, s, dn, up) > 1)
            check("R10 single steps", 32'(jumpy), 32'd0);
    endtask

    task automatic tick_period(input int p);
        int n;
        n = 0;
        while (!sys_tick && n < 40) begin step_clk(); n++; end
        step_clk();
        n = 1;
        while (!sys_tick && n < 40) begin step_clk(); n++; end
        check("R8 tick period", 32'(n), 32'(p + 1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int model;
        int seed;
        seed = int'($urandom(32'd917));
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        src_ready = 8'hFF; src_phase = 8'h00;
        repeat (4) step_clk();
        rst_n = 1;
        step_clk();

        // R1 reset state
        check("R1 ctrl", ctrl_q, 32'h0);
        check("R1 slew", slew_q, 32'h0);
        check("R1 cur", 32'(cur_src), 32'd0);
        check("R1 gate", 32'(src_gate), 32'h1);
        check("R1 ratio", 32'(post_div_now), 32'd0);

        // R2 locked and broken-sequence writes
        wr(2'd0, ctrl_word(3, 1));
        step_clk();
        check("R2 locked ctrl", ctrl_q, 32'h0);
        wr(2'd2, KA); wr(2'd1, slew_word(7, 1, 1, 1)); wr(2'd2, KB); wr(2'd0, ctrl_word(4, 1));
        step_clk();
        check("R2 broken key ctrl", ctrl_q, 32'h0);
        check("R2 broken key slew", slew_q, 32'h0);
        key_wr(2'd1, 32'h2);
        check("R2 unlocked slew", slew_q, 32'h2);
        wr(2'd1, 32'h4);
        check("R2 single use", slew_q, 32'h2);

        // R3 / R5 accepted switch with phases low
        key_wr(2'd0, ctrl_word(3, 1));
        check("R3 go and request", ctrl_q, 32'h0301);
        step_clk();
        check("R5 switched", ctrl_q, 32'h3300);
        check("R7 gate", 32'(src_gate), 32'h08);
        key_wr(2'd0, 32'h7000 | ctrl_word(3, 0));
        check("R3 current field read-only", ctrl_q, 32'h3300);

        // R5 wait on high phase, R6 writes ignored while pending
        src_phase = 8'h08;
        key_wr(2'd0, ctrl_word(6, 1));
        repeat (3) step_clk();
        check("R5 held while old high", ctrl_q, 32'h3601);
        key_wr(2'd0, ctrl_word(1, 1));
        check("R6 pending write ignored", ctrl_q, 32'h3601);
        src_phase = 8'h00;
        step_clk();
        check("R5 switch on low", ctrl_q, 32'h6600);

        // R4 refused switch: source 5 drops ready
        src_ready = 8'hDF;
        key_wr(2'd0, ctrl_word(5, 1));
        check("R4 request seen", 32'(ctrl_q[0]), 32'd1);
        step_clk();
        check("R4 refused", ctrl_q, 32'h6500);
        check("R4 gate kept", 32'(src_gate), 32'h40);
        // R4 ready falls while waiting
        src_ready = 8'hFF; src_phase = 8'h40;
        key_wr(2'd0, ctrl_word(2, 1));
        step_clk();
        check("R4 waiting", 32'(ctrl_q[0]), 32'd1);
        src_ready = 8'hFB;
        step_clk();
        check("R4 refused late", ctrl_q, 32'h6200);
        src_ready = 8'hFF; src_phase = 8'h00;

        // Random switch attempts against a bench model
        model = 6;
        for (int it = 0; it < 40; it++) begin
            int t;
            bit done;
            t = int'($urandom % 8);
            key_wr(2'd0, ctrl_word(t, 1));
            done = 0;
            for (int c = 0; c < 40 && !done; c++) begin
                logic [7:0] rdy, ph;
                rdy = 8'($urandom) | 8'h0;
                if (($urandom % 3) != 0) rdy[t] = 1'b1;
                ph = (c > 20) ? 8'h00 : 8'($urandom);
                src_ready = rdy; src_phase = ph;
                if (!rdy[t]) done = 1;
                else if (!ph[model] && !ph[t]) begin model = t; done = 1; end
                step_clk();
            end
            check("R5 random active source", 32'(cur_src), 32'(model));
            check("R4 random go cleared", 32'(ctrl_q[0]), 32'd0);
            check("R7 random gate", 32'(src_gate), 32'(8'(1) << model));
            src_ready = 8'hFF; src_phase = 8'h00;
        end

        // Post-divider: jumps, slews, direction selection
        pdiv_case("R10 slew up ratio", 5, 0, 1, 0);
        pdiv_case("R10 slew dwell 2", 9, 2, 1, 0);
        pdiv_case("R11 falling uses bit2", 2, 1, 1, 0);
        pdiv_case("R10 falling slew", 0, 3, 0, 1);
        pdiv_case("R11 rising uses bit1", 15, 7, 0, 1);
        pdiv_case("R9 same value", 15, 0, 0, 0);
        pdiv_case("R10 longest slew", 0, 7, 0, 1);
        tick_period(0);
        pdiv_case("R9 jump", 3, 0, 0, 0);
        tick_period(3);
        pdiv_case("R9 jump top", 15, 0, 0, 0);
        tick_period(15);
        for (int k = 0; k < 10; k++) begin
            pdiv_case("R10 random", int'($urandom % 16), int'($urandom % 8),
                      bit'($urandom % 2), bit'($urandom % 2));
        end
        tick_period(int'(post_div_now));

        finish_run();
    end

endmodule